// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block holds a parameterized chain of multiplexed-input scan flip-flops around a small combinational logic cloud, together with a sequencer that runs structural tests on it. In functional mode every flop loads the output of the logic cloud on each clock. In test mode a `start` pulse begins a test. The sequencer shifts a serial stimulus into the chain, applies one capture clock with scan enable low, and then shifts the captured response out. During that unload it checks each bit against a serial expected stream.

The unload shifts the next stimulus in at the same time. If `cont` is high on the final unload cycle, the sequencer goes straight into another capture, so a series of vectors runs without a separate load for each. A sticky fail flag records any mismatch. A one-cycle done pulse marks the end of the session.

The sequencer has four states: `ST_IDLE`, `ST_LOAD`, `ST_CAPTURE` and `ST_UNLOAD`. Its transitions are:
- **go**: `ST_IDLE` to `ST_LOAD`, on `start` with `test_mode` high.
- **loaded**: `ST_LOAD` to `ST_CAPTURE`, after the last load cycle.
- **captured**: `ST_CAPTURE` to `ST_UNLOAD`.
- **chain**: `ST_UNLOAD` to `ST_CAPTURE`, on the last unload cycle with `cont` high.
- **finish**: `ST_UNLOAD` to `ST_IDLE`, on the last unload cycle with `cont` low.
- **abort**: any busy state to `ST_IDLE`, when `test_mode` is low.

Top module: `scan_test_top`

## Requirements
- R1: After reset the sequencer is in ST_IDLE. All flops are 0, and `scan_en`, `busy`, `done` and `fail` are 0.
- R2: While `test_mode` is low, `scan_en` is 0 and `start` is ignored. Every clock, each flop loads its logic-cloud output. The same functional load happens in ST_IDLE.
- R3: `start` sampled high in ST_IDLE with `test_mode` high enters ST_LOAD. `scan_en` is then high for exactly CHAIN_LEN cycles before capture.
- R4: On a shift clock, flop 0 takes `scan_in` and flop i takes flop i-1. `scan_out` always shows flop CHAIN_LEN-1, the last flop.
- R5: Capture lasts exactly one cycle with `scan_en` low. In that cycle flop i loads `func_in[i] ^ (q[i] & q[(i+1) mod CHAIN_LEN])`.
- R6: `scan_en` goes high again in the cycle after capture and stays high for CHAIN_LEN unload cycles.
- R7: In each unload cycle, a `scan_out` that differs from `exp_in` sets `fail`. `fail` stays set until the next accepted `start` clears it. No comparison is made while loading.
- R8: `done` is high for one cycle, in the cycle after the last unload edge of a session. `fail` already holds its final value in that cycle.
- R9: With `cont` high on the last unload cycle, the next cycle is a capture of the data shifted in during that unload. No `done` pulse occurs, and `fail` accumulates across the chained vectors.
- R10: `test_mode` going low in any busy state returns the sequencer to ST_IDLE on the next edge, without a `done` pulse.
- R11: `busy` is high exactly while the sequencer is in ST_LOAD, ST_CAPTURE or ST_UNLOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | High enables scan testing, low forces functional operation |
| start | input | 1 | Begins a test session when sampled in ST_IDLE |
| cont | input | 1 | On the last unload cycle, chains straight into another capture |
| scan_in | input | 1 | Serial stimulus bit |
| exp_in | input | 1 | Serial expected response bit, aligned with `scan_out` |
| func_in | input | CHAIN_LEN | Primary inputs of the logic cloud |
| scan_en | output | 1 | Scan enable applied to every flop |
| scan_out | output | 1 | Output of the last flop in the chain |
| func_q | output | CHAIN_LEN | Flop contents |
| busy | output | 1 | Sequencer is running a session |
| done | output | 1 | One-cycle end-of-session pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with CHAIN_LEN set to 5. With an odd, short chain, the shift counter wraps at a value that is not a power of two, and the logic cloud's wrap-around term from the last flop to flop 0 is exercised. Every captured bit can be traced by the bench's model within a few dozen cycles. The short chain also makes it cheap to run whole sessions with mismatches at the first and last unloaded bit, chained vectors, restarts and aborts in each phase.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_UNLOAD  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic se,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);

    logic d_sel;

    always_comb begin
        d_sel = se ? d_scan : d_func;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d_sel;
        end
    end

endmodule

// File: rtl/scan_logic_cloud.sv
module scan_logic_cloud #(
    parameter int CHAIN_LEN = 16
) (
    input  logic [CHAIN_LEN-1:0] state_q,
    input  logic [CHAIN_LEN-1:0] pin_in,
    output logic [CHAIN_LEN-1:0] next_d
);

    for (genvar gi = 0; gi < CHAIN_LEN; gi++) begin : g_node
        localparam int NBR = (gi + 1) % CHAIN_LEN;
        always_comb begin
            next_d[gi] = pin_in[gi] ^ (state_q[gi] & state_q[NBR]);
        end
    end

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int CHAIN_LEN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 se,
    input  logic                 si,
    input  logic [CHAIN_LEN-1:0] d_func,
    output logic [CHAIN_LEN-1:0] q,
    output logic                 so
);

    logic [CHAIN_LEN-1:0] link;

    always_comb begin
        link = {q[CHAIN_LEN-2:0], si};
    end

    for (genvar gi = 0; gi < CHAIN_LEN; gi++) begin : g_cell
        scan_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .se    (se),
            .d_func(d_func[gi]),
            .d_scan(link[gi]),
            .q     (q[gi])
        );
    end

    always_comb begin
        so = q[CHAIN_LEN-1];
    end

    // R4: a shift clock moves every bit one place toward scan-out
    p_shift_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        se |=> (q == {$past(q[CHAIN_LEN-2:0]), $past(si)}));

    // R2 / R5: with scan enable low every flop loads the logic cloud
    p_func_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !se |=> (q == $past(d_func)));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic start,
    input  logic cont,
    input  logic so,
    input  logic exp_in,
    output logic scan_en,
    output logic busy,
    output logic done,
    output logic fail
);

    localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

    seq_state_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic at_last, go, miss;

    always_comb begin
        at_last = (cnt == LAST);
        go      = (st == ST_IDLE) && test_mode && start;
        miss    = (st == ST_UNLOAD) && test_mode && (so != exp_in);
    end

    // next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: begin
                if (go) st_n = ST_LOAD;
            end
            ST_LOAD: begin
                if (!test_mode)   st_n = ST_IDLE;
                else if (at_last) st_n = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                st_n = test_mode ? ST_UNLOAD : ST_IDLE;
            end
            ST_UNLOAD: begin
                if (!test_mode)   st_n = ST_IDLE;
                else if (at_last) st_n = cont ? ST_CAPTURE : ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_comb begin
        if ((st_n == st) && ((st == ST_LOAD) || (st == ST_UNLOAD))) begin
            cnt_n = cnt + 1'b1;
        end else begin
            cnt_n = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            done <= (st == ST_UNLOAD) && test_mode && at_last && !cont;
            if (go) begin
                fail <= 1'b0;
            end else if (miss) begin
                fail <= 1'b1;
            end
        end
    end

    always_comb begin
        scan_en = test_mode && ((st == ST_LOAD) || (st == ST_UNLOAD));
        busy    = (st != ST_IDLE);
    end

    // R3: the load phase runs its full count before it leaves for capture
    p_load_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && test_mode && !at_last) |=> (st == ST_LOAD));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R5: capture never lasts more than one cycle
    p_capture_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE) |=> (st != ST_CAPTURE));

    // R6: capture under test mode is followed by unload
    p_unload_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE && test_mode) |=> (st == ST_UNLOAD));

    // R7: fail only clears on an accepted start
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !go) |=> fail);

    // R8: done is a single-cycle pulse seen in idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st == ST_IDLE) && !$past(done));

    // R10: dropping test mode always ends the session
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode) |=> (st == ST_IDLE) && !done);

endmodule

// File: rtl/scan_test_top.sv
module scan_test_top #(
    parameter int CHAIN_LEN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_mode,
    input  logic                 start,
    input  logic                 cont,
    input  logic                 scan_in,
    input  logic                 exp_in,
    input  logic [CHAIN_LEN-1:0] func_in,
    output logic                 scan_en,
    output logic                 scan_out,
    output logic [CHAIN_LEN-1:0] func_q,
    output logic                 busy,
    output logic                 done,
    output logic                 fail
);

    logic [CHAIN_LEN-1:0] cloud_d;
    logic                 so_w;

    scan_logic_cloud #(.CHAIN_LEN(CHAIN_LEN)) u_cloud (
        .state_q(func_q),
        .pin_in (func_in),
        .next_d (cloud_d)
    );

    scan_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .se    (scan_en),
        .si    (scan_in),
        .d_func(cloud_d),
        .q     (func_q),
        .so    (so_w)
    );

    scan_sequencer #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_mode(test_mode),
        .start    (start),
        .cont     (cont),
        .so       (so_w),
        .exp_in   (exp_in),
        .scan_en  (scan_en),
        .busy     (busy),
        .done     (done),
        .fail     (fail)
    );

    always_comb begin
        scan_out = so_w;
    end

    // R2: functional mode never asserts scan enable
    p_func_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> !scan_en);

endmodule

// File: tb/scan_test_top_tb_top.sv
module scan_test_top_tb_top;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic         start = 1'b0;
    logic         cont = 1'b0;
    logic         scan_in = 1'b0;
    logic         exp_in = 1'b0;
    logic [N-1:0] func_in = '0;
    logic         scan_en, scan_out, busy, done, fail;
    logic [N-1:0] func_q;

    int checks = 0;
    int errors = 0;

    // behavioural reference model
    logic [N-1:0] mq = '0;
    int           mph = 0;   // 0 idle, 1 load, 2 capture, 3 unload
    int           mcnt = 0;
    bit           mfail = 0;
    bit           mdone = 0;
    int           done_seen = 0;

    always #2.5 clk = ~clk;

    scan_test_top #(.CHAIN_LEN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .cont(cont), .scan_in(scan_in), .exp_in(exp_in), .func_in(func_in),
        .scan_en(scan_en), .scan_out(scan_out), .func_q(func_q),
        .busy(busy), .done(done), .fail(fail)
    );

    function automatic logic [N-1:0] cloud(input logic [N-1:0] q, input logic [N-1:0] p);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = p[i] ^ (q[i] & q[(i + 1) % N]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit    se_m;
        string se_tag;
        string q_tag;
        se_m = test_mode && (mph == 1 || mph == 3);
        case (mph)
            1: se_tag = "R3";
            2: se_tag = "R5";
            3: se_tag = "R6";
            default: se_tag = "R2";
        endcase
        q_tag = se_m ? "R4" : "R5";
        chk(scan_en == se_m, se_tag, "scan_en", scan_en, se_m);
        chk(scan_out == mq[N-1], "R4", "scan_out", scan_out, mq[N-1]);
        chk(func_q == mq, q_tag, "func_q", func_q, mq);
        chk(done == mdone, "R8", "done", done, mdone);
        chk(fail == mfail, "R7", "fail", fail, mfail);
        chk(busy == (mph != 0), "R11", "busy", busy, (mph != 0));
    endtask

    // one clock: check, drive, predict
    task automatic cyc(input bit tm, input bit st, input bit ct, input bit vi,
                       input bit flip, input logic [N-1:0] fin);
        logic [N-1:0] nq;
        bit se_m;
        int nph, ncnt;
        bit nfail, ndone;
        @(negedge clk);
        compare_all();
        if (done) done_seen++;
        test_mode = tm; start = st; cont = ct; scan_in = vi;
        exp_in = mq[N-1] ^ flip; func_in = fin;
        se_m = tm && (mph == 1 || mph == 3);
        nq = se_m ? {mq[N-2:0], vi} : cloud(mq, fin);
        nph = mph; ncnt = 0; nfail = mfail; ndone = 0;
        case (mph)
            0: if (tm && st) begin nph = 1; nfail = 0; end
            1: begin
                if (!tm) nph = 0;
                else if (mcnt == N - 1) nph = 2;
                else ncnt = mcnt + 1;
            end
            2: nph = tm ? 3 : 0;
            default: begin
                if (!tm) nph = 0;
                else begin
                    if (mq[N-1] != exp_in) nfail = 1;
                    if (mcnt == N - 1) begin
                        if (ct) nph = 2;
                        else begin nph = 0; ndone = 1; end
                    end else ncnt = mcnt + 1;
                end
            end
        endcase
        mq = nq; mph = nph; mcnt = ncnt; mfail = nfail; mdone = ndone;
    endtask

    // a full session: start, load vec, capture, unload with optional chaining
    task automatic session(input logic [N-1:0] vec, input logic [N-1:0] nxt,
                           input bit chain, input int flip_at, input logic [N-1:0] fin);
        cyc(1, 1, 0, 0, 0, fin);
        for (int k = 0; k < N; k++) cyc(1, 0, 0, vec[N-1-k], 0, fin);
        cyc(1, 0, 0, 0, 0, fin);
        for (int k = 0; k < N; k++)
            cyc(1, 0, chain, nxt[N-1-k], (k == flip_at), fin);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int d0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(func_q == '0 && !scan_en && !busy && !done && !fail, "R1", "reset outputs",
            {func_q, scan_en, busy, done, fail}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: functional mode, start ignored
        for (int k = 0; k < 8; k++) cyc(0, 1, 0, 1, 0, N'(k * 7 + 3));
        chk(mph == 0 && !busy, "R2", "start ignored in functional mode", busy, 0);

        // R3 R5 R6 R7 R8: clean session
        d0 = done_seen;
        session(5'b10110, 5'b01101, 0, -1, 5'b01011);
        cyc(1, 0, 0, 0, 0, 5'b0);
        chk(done_seen == d0 + 1, "R8", "one done pulse", done_seen - d0, 1);
        chk(!fail, "R7", "clean session passes", fail, 0);

        // R7: mismatch on first unload bit
        session(5'b11111, 5'b0, 0, 0, 5'b10101);
        cyc(1, 0, 0, 0, 0, 5'b0);
        chk(fail, "R7", "first-bit mismatch sticks", fail, 1);
        cyc(1, 0, 0, 0, 0, 5'b0);
        chk(fail, "R7", "fail held in idle", fail, 1);

        // R7: restart clears, mismatch on last bit
        cyc(1, 1, 0, 0, 0, 5'b0);
        cyc(1, 0, 0, 1, 0, 5'b0);
        chk(!fail, "R7", "start clears fail", fail, 0);
        for (int k = 0; k < N - 1; k++) cyc(1, 0, 0, k[0], 0, 5'b00111);
        cyc(1, 0, 0, 0, 0, 5'b00111);
        for (int k = 0; k < N; k++) cyc(1, 0, 0, 0, (k == N - 1), 5'b00111);
        cyc(1, 0, 0, 0, 0, 5'b0);
        chk(fail, "R7", "last-bit mismatch", fail, 1);

        // R9: chained vectors, mismatch only in first, no done until end
        d0 = done_seen;
        session(5'b01010, 5'b11001, 1, 2, 5'b11100);
        chk(mph == 2, "R9", "chain enters capture", mph, 2);
        cyc(1, 0, 0, 0, 0, 5'b10011);
        for (int k = 0; k < N; k++) cyc(1, 0, 0, 1, 0, 5'b10011);
        cyc(1, 0, 0, 0, 0, 5'b0);
        chk(done_seen == d0 + 1, "R9", "single done after chain", done_seen - d0, 1);
        chk(fail, "R9", "fail accumulates over chain", fail, 1);

        // R10: abort in load, capture and unload
        d0 = done_seen;
        cyc(1, 1, 0, 0, 0, 5'b0);
        cyc(1, 0, 0, 1, 0, 5'b0);
        cyc(0, 0, 0, 1, 0, 5'b01110);
        cyc(0, 0, 0, 0, 0, 5'b01110);
        chk(!busy, "R10", "abort in load", busy, 0);
        cyc(1, 1, 0, 0, 0, 5'b0);
        for (int k = 0; k < N; k++) cyc(1, 0, 0, 1, 0, 5'b0);
        cyc(0, 0, 0, 0, 0, 5'b11011);
        cyc(0, 0, 0, 0, 0, 5'b0);
        chk(!busy, "R10", "abort in capture", busy, 0);
        cyc(1, 1, 0, 0, 0, 5'b0);
        for (int k = 0; k < N; k++) cyc(1, 0, 0, 1, 0, 5'b0);
        cyc(1, 0, 0, 0, 0, 5'b00100);
        cyc(1, 0, 0, 0, 0, 5'b0);
        cyc(0, 0, 0, 0, 0, 5'b0);
        cyc(1, 0, 0, 0, 0, 5'b0);
        chk(done_seen == d0, "R10", "no done after aborts", done_seen - d0, 0);

        cyc(1, 0, 0, 0, 0, 5'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule